// File: doc/BRIEF.md
# ULPI Viewport Register Bridge

This block gives software indirect access to the byte-wide control registers of a USB ULPI transceiver through one 32-bit memory-mapped word. Software loads a PHY register address, a write byte, a direction flag and a start flag into the word in a single store. The bridge then performs one access on a small PHY register bank held inside the block. On a read it places the returned byte in a read-data field. It then drops the start flag so that software can poll for completion.

The PHY bank covers addresses 0x00 through 0x18. It comes out of reset with fixed identity bytes and includes a freely usable scratch byte. Only a defined set of bits in the word accepts software stores, so status and result fields cannot be corrupted by a careless write. The bus side is a plain register port: a select that marks an address match, separate write and read strobes, write data and registered read data.

Top module: `ulpi_vport_bridge`

## Requirements
- R1: After reset the viewport word reads 0x08000000, with bit 27 (sync state) set. The PHY bank holds 0x24, 0x04, 0x04 and 0x00 at PHY addresses 0x00, 0x01, 0x02 and 0x03.
- R2: A store with no access in progress changes only the bits under mask 0xE0FF00FF. Those are bits 7:0 (write byte), 23:16 (PHY address), 29 (direction, 1 = write), 30 (run) and 31 (wakeup). Every other bit, including read data in bits 15:8 and sync state, keeps its value.
- R3: The wakeup bit (bit 31) reads 0 after any store, including a store that sets it.
- R4: A store that sets run keeps bit 30 at 1 for BUSY_CYC (default 2) clock cycles after the store edge. It then reads 0 from the following edge on.
- R5: A completed access with bit 29 = 1 writes the bits 7:0 byte into the PHY register selected by bits 23:16.
- R6: A completed access with bit 29 = 0 copies the selected PHY register byte into bits 15:8.
- R7: The scratch byte at PHY address 0x16 and the last bank entry at 0x18 can be written and read back.
- R8: A PHY address above 0x18 reads as 0x00, and a write to it changes no bank entry.
- R9: A store arriving while run is set is ignored and leaves the word and the bank unchanged.
- R10: A read strobe returns the whole viewport word as it stood before that clock edge, on bus_rdata from the next edge. A read during an access therefore shows run set and the previous read data.
- R11: Strobes with bus_sel low have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Address match for the viewport word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
A store takes effect at its own clock edge. The run bit then stays visible for exactly two more edges, and the PHY access and result capture land on the second of those. Read data appears one edge after its strobe. The bench drives each strobe for one cycle from the falling edge. It queues the expected word when a read is issued, and a monitor compares bus_rdata on the falling edge after the strobe's rising edge. Completion results are read three edges after the store; busy-state reads are placed one and two edges after it.

// File: rtl/ulpi_vp_pkg.sv
// Package: field positions, writable mask and reset values shared by the
// viewport bridge. Assumes a 32-bit viewport and byte-wide PHY registers.
package ulpi_vp_pkg;
    localparam int VP_W      = 32;
    localparam int BYTE_W    = 8;
    localparam int WDATA_LSB = 0;
    localparam int RDATA_LSB = 8;
    localparam int ADDR_LSB  = 16;
    localparam int SYNC_BIT  = 27;
    localparam int DIR_BIT   = 29;
    localparam int RUN_BIT   = 30;
    localparam int WAKE_BIT  = 31;

    localparam logic [VP_W-1:0] SW_MASK  = 32'hE0FF_00FF;
    localparam logic [VP_W-1:0] VP_RESET = 32'h0800_0000;

    // Reset content of a PHY register: identity bytes low, zero elsewhere.
    function automatic logic [BYTE_W-1:0] phy_default(input int idx);
        case (idx)
            0:       return 8'h24;
            1:       return 8'h04;
            2:       return 8'h04;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ulpi_phy_bank.sv
// Module: byte-wide PHY register bank with fixed reset contents.
// Assumes at most one write per cycle; out-of-range addresses read zero and
// ignore writes.
module ulpi_phy_bank
    import ulpi_vp_pkg::*;
#(
    parameter int DEPTH  = 25,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [BYTE_W-1:0] RST_VAL = phy_default(i);
        // Hold one PHY byte: reset to its identity value, load on a match.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= RST_VAL;
            else if (wr_en && (addr == ADDR_W'(i)))
                mem[i] <= wdata;
        end
    end

    // Select the addressed byte, zero when no entry matches.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (addr == ADDR_W'(i)) rdata = mem[i];
    end

    // Write landing: an in-range write is visible at its address next cycle.
    assert_wr_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr < ADDR_W'(DEPTH))) |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/ulpi_vp_ctrl.sv
// Module: viewport word and access sequencer. Holds the 32-bit word, applies
// the writable mask, clears wakeup, and runs one PHY access BUSY_CYC edges
// after a store that sets run. Assumes stores during an access are dropped.
module ulpi_vp_ctrl
    import ulpi_vp_pkg::*;
#(
    parameter int BUSY_CYC = 2,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [VP_W-1:0]   wdata,
    input  logic [BYTE_W-1:0] bank_rdata,
    output logic [VP_W-1:0]   word,
    output logic              bank_wr_en,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [BYTE_W-1:0] bank_wdata
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic             done;
    logic [VP_W-1:0]  store_val;

    assign busy = word[RUN_BIT];
    assign done = busy && (cnt == CNT_W'(1));

    // Merge a store into the word under the mask; wakeup never sticks.
    always_comb begin
        store_val = (word & ~SW_MASK) | (wdata & SW_MASK);
        store_val[WAKE_BIT] = 1'b0;
    end

    // Sequence stores, the busy window and access completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= VP_RESET;
            cnt  <= '0;
        end else if (done) begin
            word[RUN_BIT] <= 1'b0;
            if (!word[DIR_BIT])
                word[RDATA_LSB +: BYTE_W] <= bank_rdata;
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
        end else if (wr_stb) begin
            word <= store_val;
            cnt  <= wdata[RUN_BIT] ? CNT_W'(BUSY_CYC) : '0;
        end
    end

    assign bank_wr_en = done && word[DIR_BIT];
    assign bank_addr  = word[ADDR_LSB +: ADDR_W];
    assign bank_wdata = word[WDATA_LSB +: BYTE_W];

    // Protected bits survive an accepted store.
    assert_ro_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !busy) |=> ((word & ~SW_MASK) == ($past(word) & ~SW_MASK)));
    // Wakeup reads back as zero after any accepted store.
    assert_wake_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !busy) |=> !word[WAKE_BIT]);
    // Run drops right after the completing edge.
    assert_run_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !word[RUN_BIT]);
    // A read access captures the bank byte into the result field.
    assert_read_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !word[DIR_BIT]) |=> (word[RDATA_LSB +: BYTE_W] == $past(bank_rdata)));
    // The word is frozen while an access is pending.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(word));
endmodule

// File: rtl/ulpi_vp_rdport.sv
// Module: registered read return. Captures the whole viewport word on a
// selected read strobe and holds it until the next one.
module ulpi_vp_rdport
    import ulpi_vp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic [VP_W-1:0] word,
    output logic [VP_W-1:0] rdata
);
    // Latch the pre-edge word when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_stb)
            rdata <= word;
    end

    // A strobe returns the word from before its edge.
    assert_rd_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rdata == $past(word)));
endmodule

// File: rtl/ulpi_vport_bridge.sv
// Module: top of the ULPI viewport bridge. Decodes the bus strobes and
// ties the sequencer, the PHY bank and the read return together.
// Assumes full 32-bit accesses only.
module ulpi_vport_bridge
    import ulpi_vp_pkg::*;
#(
    parameter int BUSY_CYC  = 2,
    parameter int PHY_DEPTH = 25,
    parameter int PHY_AW    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic              wr_stb;
    logic              rd_stb;
    logic [VP_W-1:0]   word;
    logic              bank_wr_en;
    logic [PHY_AW-1:0] bank_addr;
    logic [BYTE_W-1:0] bank_wdata;
    logic [BYTE_W-1:0] bank_rdata;

    assign wr_stb = bus_sel && bus_wr;
    assign rd_stb = bus_sel && bus_rd;

    ulpi_vp_ctrl #(.BUSY_CYC(BUSY_CYC), .ADDR_W(PHY_AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wdata      (bus_wdata),
        .bank_rdata (bank_rdata),
        .word       (word),
        .bank_wr_en (bank_wr_en),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata)
    );

    ulpi_phy_bank #(.DEPTH(PHY_DEPTH), .ADDR_W(PHY_AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_wr_en),
        .addr  (bank_addr),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );

    ulpi_vp_rdport u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_stb),
        .word   (word),
        .rdata  (bus_rdata)
    );

    // Unselected stores leave the word alone.
    assert_nosel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !word[RUN_BIT]) |=> $stable(word));
endmodule

// File: tb/ulpi_vport_bridge_test.sv
`timescale 1ns/100ps
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module ulpi_vport_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    ulpi_vport_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Monitor: note a read strobe at the edge, compare on the next falling edge.
    always begin
        logic hit;
        @(posedge clk);
        hit = bus_sel && bus_rd;
        @(negedge clk);
        if (hit && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s actual=%08h expected=%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [31:0] d, input logic sel = 1'b1);
        bus_sel = sel; bus_wr = 1'b1; bus_rd = 1'b0; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // Start a PHY read and check the completed word three edges later.
    task automatic phy_read(input logic [7:0] a, input logic [7:0] v, input string t);
        wr(32'h4000_0000 | (32'(a) << 16));
        idle(); idle();
        rd(32'h0800_0000 | (32'(a) << 16) | (32'(v) << 8), t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(32'h0800_0000, "R1 reset word");
        phy_read(8'h03, 8'h00, "R1/R6 product id high");
        phy_read(8'h02, 8'h04, "R1/R6 product id low");
        phy_read(8'h01, 8'h04, "R1/R6 vendor id high");
        phy_read(8'h00, 8'h24, "R1/R6 vendor id low");
        // Protected bits only: nothing changes except cleared fields.
        wr(32'h1F00_FF00);
        rd(32'h0800_2400, "R2 protected bits kept");
        // All ones: wakeup cleared, run visible two cycles, out-of-range write.
        wr(32'hFFFF_FFFF);
        rd(32'h68FF_24FF, "R3/R4/R10 busy read 1");
        rd(32'h68FF_24FF, "R4/R10 busy read 2");
        rd(32'h28FF_24FF, "R4 run cleared");
        // Scratch write and readback.
        wr(32'h6016_00A5); idle(); idle();
        rd(32'h2816_24A5, "R5 write completed word");
        phy_read(8'h16, 8'hA5, "R7 scratch readback");
        // Last entry of the bank.
        wr(32'h6018_005A); idle(); idle();
        rd(32'h2818_A55A, "R5 write at last entry");
        phy_read(8'h18, 8'h5A, "R7 last entry readback");
        // Beyond the bank.
        wr(32'h6019_0077); idle(); idle();
        phy_read(8'h19, 8'h00, "R8 out of range reads zero");
        // Store during an access is dropped.
        wr(32'h4000_0000);
        wr(32'h6016_0011);
        idle();
        rd(32'h0800_2400, "R9 busy store ignored (word)");
        phy_read(8'h16, 8'hA5, "R9 busy store ignored (bank)");
        // Unselected store.
        wr(32'h6016_0033, 1'b0);
        rd(32'h0816_A500, "R11 unselected store ignored");
        idle(); idle();
        phy_read(8'h16, 8'hA5, "R11 bank untouched");
        // Explicit wakeup.
        wr(32'h8000_0000);
        rd(32'h0800_A500, "R3 wakeup self-clears");
        idle(); idle();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule